// File: doc/BRIEF.md
# Axis-by-Axis Motion Search Sequencer

This block drives a coarse-to-fine block-matching search for one block of a video frame. It does not compute distortion. It produces a stream of candidate displacements, and an external engine answers each one with a sum of absolute differences (SAD). While it runs, the block keeps the lowest SAD it has seen. When the last scan ends, it reports the winning motion vector together with a one-cycle done pulse.

The search is made of line scans along one axis at a time. The first pass is centred on zero displacement:

- A horizontal line scan covers every offset from -`SEARCH_P` to +`SEARCH_P`.
- A vertical line scan follows. It is centred on the best horizontal position.

Each later pass is centred on the result of the pass before it. It repeats the horizontal-then-vertical pair with the range halved, but never below 1. The number of passes is `PASSES`, which defaults to 2.

A candidate that would leave the allowed window ±`WIN_P` is skipped and never requested. Only one request is outstanding at any time, so each step waits until the result of the step before it is known.

Top module: `ose_search_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until `start` is seen, `req_valid`, `rsp_ready` and `done` are all low.
- R2: After `start`, the first scan requests (x, 0) for x = -SEARCH_P up to +SEARCH_P in ascending order. Each request is accepted on `req_valid && req_ready`. No new request is made until a response is accepted on `rsp_valid && rsp_ready`. `req_valid` and `rsp_ready` are never high together.
- R3: The second scan requests (bx, y) for y ascending over the same range. Here bx is the x of the lowest SAD in the first scan.
- R4: Every later pass uses a range of half the previous range, rounded down and at least 1. Its centre is the result of the previous pass. It scans horizontally and then vertically, in ascending offset order, exactly like the first pass.
- R5: A candidate with |dx| > WIN_P or |dy| > WIN_P is skipped without a request. No request ever leaves the window.
- R6: In each scan, the lowest SAD (unsigned) wins. On equal SAD, the earliest candidate requested is kept.
- R7: After the last scan's final response, `done` is high for exactly one cycle. `mv_x` and `mv_y` then hold the position chosen by the last vertical scan, as two's-complement values. The block then returns to idle and accepts a new `start`.
- R8: While `req_valid` is high and `req_ready` is low, the request coordinates hold steady. Any `rsp_valid` pulse while `rsp_ready` is low is ignored.
- R9: `start` has no effect while a search is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search (sampled only when idle) |
| req_valid | output | 1 | Candidate request pending |
| req_ready | input | 1 | Engine accepts the request |
| req_dx | output | MV_W | Candidate horizontal displacement, signed |
| req_dy | output | MV_W | Candidate vertical displacement, signed |
| rsp_valid | input | 1 | Engine returns a SAD |
| rsp_ready | output | 1 | Block is waiting for a SAD |
| rsp_sad | input | SAD_W | Distortion of the last accepted candidate |
| done | output | 1 | One-cycle end-of-search pulse |
| mv_x | output | MV_W | Final horizontal motion vector, signed |
| mv_y | output | MV_W | Final vertical motion vector, signed |

## Verification
The bench exercises four kinds of distortion surface:
- Every candidate given the same SAD, to check R6. A design that kept the last tie instead of the first would finish at (+7, …) instead of (-7, -7).
- A checkerboard with many ties, also aimed at R6.
- A surface centred on a target at a window edge. Here the second pass must skip candidates, and a design that failed to skip would request a displacement beyond ±7.
- Random target surfaces with noise.

Each request is compared against a sequence the bench builds on its own, so a wrong re-centring or an unhalved second-pass range shows up at the first mismatching candidate. The bench also stalls `req_ready` while it pulses `rsp_valid` and `start`. A design that took those pulses would accept a stray SAD or restart mid-search, and the request sequence would break.

// File: rtl/ose_pkg.sv
package ose_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } ose_state_e;

    typedef enum logic {
        AX_HORZ = 1'b0,
        AX_VERT = 1'b1
    } ose_axis_e;

endpackage

// File: rtl/ose_cand_gen.sv
module ose_cand_gen #(
    parameter int CW    = 5,
    parameter int WIN_P = 7
) (
    input  ose_pkg::ose_axis_e    axis,
    input  logic signed [CW-1:0]  cx,
    input  logic signed [CW-1:0]  cy,
    input  logic signed [CW-1:0]  off,
    output logic signed [CW-1:0]  cand_x,
    output logic signed [CW-1:0]  cand_y,
    output logic                  in_win
);
    localparam logic signed [CW-1:0] WHI = CW'(WIN_P);
    localparam logic signed [CW-1:0] WLO = -WHI;

    logic x_ok, y_ok;

    always_comb begin
        if (axis == ose_pkg::AX_HORZ) begin
            cand_x = cx + off;
            cand_y = cy;
        end else begin
            cand_x = cx;
            cand_y = cy + off;
        end
        x_ok   = (cand_x >= WLO) && (cand_x <= WHI);
        y_ok   = (cand_y >= WLO) && (cand_y <= WHI);
        in_win = x_ok && y_ok;
    end

endmodule

// File: rtl/ose_min_track.sv
module ose_min_track #(
    parameter int SAD_W = 16,
    parameter int CW    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  upd,
    input  logic [SAD_W-1:0]      sad,
    input  logic signed [CW-1:0]  pos_x,
    input  logic signed [CW-1:0]  pos_y,
    output logic signed [CW-1:0]  best_x,
    output logic signed [CW-1:0]  best_y,
    output logic [SAD_W-1:0]      best_sad,
    output logic                  has_best
);
    typedef struct packed {
        logic                 has;
        logic [SAD_W-1:0]     sad;
        logic signed [CW-1:0] x;
        logic signed [CW-1:0] y;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (clr) begin
            trk_d.has = 1'b0;
        end else if (upd) begin
            // strict less-than keeps the earliest candidate on a tie
            if (!trk_q.has || (sad < trk_q.sad)) begin
                trk_d.has = 1'b1;
                trk_d.sad = sad;
                trk_d.x   = pos_x;
                trk_d.y   = pos_y;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign best_x   = trk_q.x;
    assign best_y   = trk_q.y;
    assign best_sad = trk_q.sad;
    assign has_best = trk_q.has;

    // R6: the running minimum never rises within a scan
    assert_min_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr && trk_q.has) |=> (trk_q.sad <= $past(trk_q.sad)));

    // R6: a strictly smaller SAD is always taken
    assert_min_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr && trk_q.has && (sad < trk_q.sad)) |=> (trk_q.sad == $past(sad)));

endmodule

// File: rtl/ose_search_ctrl.sv
module ose_search_ctrl #(
    parameter int SEARCH_P = 7,
    parameter int WIN_P    = 7,
    parameter int PASSES   = 2,
    parameter int SAD_W    = 16,
    parameter int MV_W     = $clog2(WIN_P + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic signed [MV_W-1:0]  req_dx,
    output logic signed [MV_W-1:0]  req_dy,
    input  logic                    rsp_valid,
    output logic                    rsp_ready,
    input  logic [SAD_W-1:0]        rsp_sad,
    output logic                    done,
    output logic signed [MV_W-1:0]  mv_x,
    output logic signed [MV_W-1:0]  mv_y
);
    import ose_pkg::*;

    localparam int CW = $clog2(WIN_P + SEARCH_P + 2) + 1;
    localparam int PW = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam logic signed [CW-1:0] RNG0 = CW'(SEARCH_P);
    localparam logic signed [CW-1:0] ONE  = CW'(1);
    localparam logic [PW-1:0]        LAST = PW'(PASSES - 1);

    typedef struct packed {
        ose_state_e            st;
        ose_axis_e             axis;
        logic [PW-1:0]         pass;
        logic signed [CW-1:0]  rng;
        logic signed [CW-1:0]  cx;
        logic signed [CW-1:0]  cy;
        logic signed [CW-1:0]  off;
        logic signed [MV_W-1:0] mvx;
        logic signed [MV_W-1:0] mvy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic signed [CW-1:0] cand_x, cand_y;
    logic                 cand_ok;
    logic signed [CW-1:0] best_x, best_y;
    logic [SAD_W-1:0]     best_sad;
    logic                 has_best;
    logic                 trk_clr, trk_upd;
    logic signed [CW-1:0] half_rng;

    ose_cand_gen #(
        .CW    (CW),
        .WIN_P (WIN_P)
    ) u_cand (
        .axis   (ctl_q.axis),
        .cx     (ctl_q.cx),
        .cy     (ctl_q.cy),
        .off    (ctl_q.off),
        .cand_x (cand_x),
        .cand_y (cand_y),
        .in_win (cand_ok)
    );

    ose_min_track #(
        .SAD_W (SAD_W),
        .CW    (CW)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (trk_clr),
        .upd      (trk_upd),
        .sad      (rsp_sad),
        .pos_x    (cand_x),
        .pos_y    (cand_y),
        .best_x   (best_x),
        .best_y   (best_y),
        .best_sad (best_sad),
        .has_best (has_best)
    );

    assign half_rng = (ctl_q.rng > ONE) ? (ctl_q.rng >>> 1) : ONE;

    always_comb begin
        ctl_d   = ctl_q;
        trk_clr = 1'b0;
        trk_upd = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st   = ST_SEEK;
                    ctl_d.axis = AX_HORZ;
                    ctl_d.pass = '0;
                    ctl_d.rng  = RNG0;
                    ctl_d.cx   = '0;
                    ctl_d.cy   = '0;
                    ctl_d.off  = -RNG0;
                    trk_clr    = 1'b1;
                end
            end
            ST_SEEK: begin
                if (ctl_q.off > ctl_q.rng) begin
                    // scan finished: re-centre on its winner
                    if (ctl_q.axis == AX_HORZ) begin
                        ctl_d.cx   = best_x;
                        ctl_d.axis = AX_VERT;
                        ctl_d.off  = -ctl_q.rng;
                        trk_clr    = 1'b1;
                    end else if (ctl_q.pass == LAST) begin
                        ctl_d.mvx = best_x[MV_W-1:0];
                        ctl_d.mvy = best_y[MV_W-1:0];
                        ctl_d.st  = ST_DONE;
                    end else begin
                        ctl_d.pass = ctl_q.pass + 1'b1;
                        ctl_d.rng  = half_rng;
                        ctl_d.off  = -half_rng;
                        ctl_d.cx   = best_x;
                        ctl_d.cy   = best_y;
                        ctl_d.axis = AX_HORZ;
                        trk_clr    = 1'b1;
                    end
                end else if (cand_ok) begin
                    ctl_d.st = ST_REQ;
                end else begin
                    ctl_d.off = ctl_q.off + ONE;
                end
            end
            ST_REQ: begin
                if (req_ready) begin
                    ctl_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    trk_upd   = 1'b1;
                    ctl_d.off = ctl_q.off + ONE;
                    ctl_d.st  = ST_SEEK;
                end
            end
            ST_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_valid = (ctl_q.st == ST_REQ);
    assign rsp_ready = (ctl_q.st == ST_WAIT);
    assign done      = (ctl_q.st == ST_DONE);
    assign req_dx    = cand_x[MV_W-1:0];
    assign req_dy    = cand_y[MV_W-1:0];
    assign mv_x      = ctl_q.mvx;
    assign mv_y      = ctl_q.mvy;

    // R2: one outstanding transaction at a time
    assert_one_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && rsp_ready));

    // R2: an accepted request is followed by waiting for its SAD
    assert_req_then_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_ready && !req_valid));

    // R5: requests stay inside the window
    assert_req_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((int'(req_dx) <= WIN_P) && (int'(req_dx) >= -WIN_P) &&
                       (int'(req_dy) <= WIN_P) && (int'(req_dy) >= -WIN_P)));

    // R8: a stalled request holds its coordinates
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_dx) && $stable(req_dy)));

    // R7: done is a single-cycle pulse followed by idle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !req_valid && !rsp_ready));

    // R7: the reported vector lies in the window
    assert_mv_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((int'(mv_x) <= WIN_P) && (int'(mv_x) >= -WIN_P) &&
                  (int'(mv_y) <= WIN_P) && (int'(mv_y) >= -WIN_P)));

    // R6: a scan never ends without a winner
    assert_scan_has_best_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> has_best);

endmodule

// File: tb/test_ose_search_ctrl.sv
module test_ose_search_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int P    = 7;
    localparam int W    = 7;
    localparam int NP   = 2;
    localparam int SW   = 16;
    localparam int MVW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic req_ready = 1'b0;
    logic rsp_valid = 1'b0;
    logic [SW-1:0] rsp_sad = '0;
    logic req_valid, rsp_ready, done;
    logic signed [MVW-1:0] req_dx, req_dy, mv_x, mv_y;

    ose_search_ctrl #(
        .SEARCH_P (P), .WIN_P (W), .PASSES (NP), .SAD_W (SW), .MV_W (MVW)
    ) i_ose_search_ctrl (
        .clk (clk), .rst_n (rst_n), .start (start),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_dx (req_dx), .req_dy (req_dy),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_sad (rsp_sad),
        .done (done), .mv_x (mv_x), .mv_y (mv_y)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int mode, tx, ty, nz;
    int ex [0:63];
    int ey [0:63];
    int es [0:63];
    int ncand, emx, emy;

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int sad_of(int x, int y);
        case (mode)
            1: return 100;
            2: return (((x + y) & 1) != 0) ? 50 : 40;
            default: return iabs(x - tx) * 3 + iabs(y - ty) * 2
                            + (((x + 16) * 5 + (y + 16) * 11 + nz) % 4);
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // independent model of the request sequence and result
    task automatic build();
        int cx = 0, cy = 0, r = P;
        int b, bp;
        bit have;
        ncand = 0;
        for (int ps = 0; ps < NP; ps++) begin
            if (ps > 0) r = (r > 1) ? r / 2 : 1;
            for (int ax = 0; ax < 2; ax++) begin
                have = 1'b0; b = 0; bp = 0;
                for (int o = -r; o <= r; o++) begin
                    int x = (ax == 0) ? cx + o : cx;
                    int y = (ax == 0) ? cy : cy + o;
                    if (iabs(x) <= W && iabs(y) <= W) begin
                        ex[ncand] = x; ey[ncand] = y; es[ncand] = ps * 2 + ax;
                        ncand++;
                        if (!have || sad_of(x, y) < b) begin
                            have = 1'b1; b = sad_of(x, y); bp = (ax == 0) ? x : y;
                        end
                    end
                end
                if (ax == 0) cx = bp; else cy = bp;
            end
        end
        emx = cx; emy = cy;
    endtask

    task automatic run_search();
        bit got;
        string tag;
        build();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < ncand; k++) begin
            got = 1'b0;
            for (int t = 0; t < 40 && !got; t++) begin
                if (req_valid) got = 1'b1; else @(negedge clk);
            end
            tag = (es[k] == 0) ? "R2 horizontal order" :
                  (es[k] == 1) ? "R3 vertical order" : "R4 refine order";
            chk(got, tag, 0, 1);
            if (!got) return;
            chk(int'(req_dx) == ex[k], tag, int'(req_dx), ex[k]);
            chk(int'(req_dy) == ey[k], tag, int'(req_dy), ey[k]);
            chk(iabs(int'(req_dx)) <= W && iabs(int'(req_dy)) <= W, "R5 window",
                int'(req_dx), W);
            // stall with stray response and stray start: both ignored
            for (int s = 0, n = int'($urandom_range(0, 2)); s < n; s++) begin
                rsp_valid = 1'b1; rsp_sad = '0;
                start = ($urandom_range(0, 3) == 0);
                @(negedge clk);
                rsp_valid = 1'b0; start = 1'b0;
                chk(req_valid && int'(req_dx) == ex[k] && int'(req_dy) == ey[k],
                    "R8 hold under stall", int'(req_dx), ex[k]);
            end
            req_ready = 1'b1;
            @(negedge clk) req_ready = 1'b0;
            chk(!req_valid && rsp_ready, "R2 wait after accept", int'(rsp_ready), 1);
            for (int s = 0, n = int'($urandom_range(0, 2)); s < n; s++) begin
                start = (s == 0) && (k % 5 == 2);   // R9 start while busy
                @(negedge clk);
                start = 1'b0;
            end
            rsp_valid = 1'b1;
            rsp_sad = SW'(sad_of(ex[k], ey[k]));
            @(negedge clk) rsp_valid = 1'b0;
        end
        got = 1'b0;
        for (int t = 0; t < 40 && !got; t++) begin
            if (done) got = 1'b1;
            else begin
                chk(!req_valid, "R9 no extra request", int'(req_valid), 0);
                @(negedge clk);
            end
        end
        chk(got, "R7 done seen", 0, 1);
        chk(int'(mv_x) == emx, "R6 R7 mv_x", int'(mv_x), emx);
        chk(int'(mv_y) == emy, "R6 R7 mv_y", int'(mv_y), emy);
        @(negedge clk);
        chk(!done, "R7 done pulse width", int'(done), 0);
        @(negedge clk);
        chk(!req_valid && !rsp_ready, "R7 back to idle", int'(req_valid), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!req_valid && !rsp_ready && !done, "R1 reset outputs", int'(req_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!req_valid && !rsp_ready && !done, "R1 idle outputs", int'(done), 0);

        // all ties: first candidates win (R6), corner result (-7,-7)
        mode = 1; tx = 0; ty = 0; nz = 0;
        run_search();
        chk(emx == -7 && emy == -7, "R6 tie model", emx, -7);
        // checkerboard ties
        mode = 2; run_search();
        // target at window corner: refine pass skips candidates (R5)
        mode = 0; tx = 7; ty = -7; nz = 1;
        run_search();
        chk(ncand < 4 * (2 * P + 1) - 2 * 8, "R5 skip count", ncand, 44);
        mode = 0; tx = -7; ty = 7; nz = 2;
        run_search();
        // random surfaces
        for (int i = 0; i < 16; i++) begin
            mode = 0;
            tx = int'($urandom_range(0, 14)) - 7;
            ty = int'($urandom_range(0, 14)) - 7;
            nz = int'($urandom_range(0, 3));
            run_search();
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule